// File: doc/BRIEF.md
# Streaming Fixed-Header Packet Parser

This block walks a packet that arrives as a byte stream, one byte on each clock where the input qualifier is high. A fixed header comes first: a 32-bit source address, a 32-bit destination address and a 16-bit payload length, each sent most-significant byte first. The parser copies each header field into its own output register at the clock edge that consumes the field's final byte. It then counts off the payload bytes named by the length field and writes each one into a 32-entry byte store at its offset within the payload.

A one-cycle completion strobe marks the end of a well-formed packet. A length above 32 marks the packet as malformed. In that case the parser raises an error flag in place of the strobe and goes straight back to waiting for a new header. The next packet may start on the very next byte, so a stream of packets needs no idle cycles between them. Cycles with the qualifier low stall the walk and change nothing.

Top module: `pkt_hdr_parser`

## Requirements
- R1: A byte is consumed at a rising clock edge only when `in_valid` is high. Cycles with `in_valid` low leave all outputs and the parse position unchanged.
- R2: Header byte order is fixed. Bytes 0 to 3 form `src_addr`, bytes 4 to 7 form `dst_addr`, and bytes 8 and 9 form `pay_len`. Each field is assembled with its first byte in the most significant position.
- R3: Each field register takes its new value at the clock edge that consumes the field's last byte. It holds its previous value while the field's earlier bytes arrive and until that same field completes in a later packet.
- R4: Payload byte k (k = 0 to 31) is written to store entry k. `rd_byte` returns entry `rd_idx` combinationally.
- R5: `pkt_done` is high for exactly the one cycle after the edge that consumes the last payload byte. The three field registers hold that packet's values during that cycle.
- R6: A length above 32 (all 16 bits compared) sets `pkt_err` after the edge that consumes the second length byte. It gives no `pkt_done` and writes no payload. The next byte is taken as the first source byte of a new packet.
- R7: A length of zero raises `pkt_done` in the cycle after the second length byte is consumed.
- R8: The byte that follows a completed or rejected packet, including one in the very next cycle, is parsed as byte 0 of a new packet.
- R9: `pkt_err` stays high until the first byte of the next packet is consumed, and it is low after that edge.
- R10: A synchronous active-high `rst` returns the parser to the start of a header and clears `pkt_done`, `pkt_err` and the three field registers to zero. Bytes presented during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Stream byte |
| src_addr | output | 32 | Latched source address |
| dst_addr | output | 32 | Latched destination address |
| pay_len | output | 16 | Latched payload length |
| pkt_done | output | 1 | One-cycle strobe for a well-formed packet |
| pkt_err | output | 1 | Held flag for a malformed length |
| rd_idx | input | 5 | Payload store read index |
| rd_byte | output | 8 | Payload store entry at `rd_idx` |

## Verification
The bench sweeps every payload length from 0 to 33 and gives each packet field bytes that are distinct and position-dependent. A wrong byte order or a latch one byte early or late therefore shows up in the field values. Alternate packets carry idle gaps at varied positions, which separates a parser that stalls correctly from one that counts idle cycles. The other packets run back to back, which shows whether the parser re-arms with no gap. Lengths with a non-zero upper byte, the all-ones length, an error followed at once by a good packet, and a reset in the middle of a header target the full-width compare, clearing of the error flag, and reset recovery.

// File: rtl/pkt_parser_pkg.sv
`timescale 1ns/1ps
package pkt_parser_pkg;
    typedef enum logic [1:0] {
        ST_SRC,
        ST_DST,
        ST_LEN,
        ST_PAY
    } parse_st_e;
endpackage

// File: rtl/pkt_hdr_fsm.sv
`timescale 1ns/1ps
module pkt_hdr_fsm
    import pkt_parser_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_BYTES  = 2,
    parameter int MAX_PAY    = 32,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int LEN_W     = 8 * LEN_BYTES,
    localparam int ACC_W     = (ADDR_W > LEN_W) ? ADDR_W : LEN_W,
    localparam int OFF_W     = $clog2(MAX_PAY),
    localparam int CNT_W     = $clog2(((MAX_PAY > ADDR_BYTES) ? MAX_PAY : ADDR_BYTES) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic [ACC_W-1:0] hdr_word,
    output logic             ld_src,
    output logic             ld_dst,
    output logic             ld_len,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_off,
    output logic             pkt_done,
    output logic             pkt_err
);
    typedef struct packed {
        parse_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-9:0] acc;
        logic [CNT_W-1:0] plast;
        logic             done;
        logic             err;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [LEN_W-1:0] len_word;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        ld_src     = 1'b0;
        ld_dst     = 1'b0;
        ld_len     = 1'b0;
        wr_en      = 1'b0;
        hdr_word   = {cur_q.acc, in_byte};
        len_word   = hdr_word[LEN_W-1:0];
        wr_off     = cur_q.cnt[OFF_W-1:0];
        if (in_valid) begin
            unique case (cur_q.st)
                ST_SRC: begin
                    nxt_d.acc = hdr_word[ACC_W-9:0];
                    if (cur_q.cnt == '0) nxt_d.err = 1'b0;
                    if (cur_q.cnt == CNT_W'(ADDR_BYTES - 1)) begin
                        ld_src    = 1'b1;
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_DST;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_DST: begin
                    nxt_d.acc = hdr_word[ACC_W-9:0];
                    if (cur_q.cnt == CNT_W'(ADDR_BYTES - 1)) begin
                        ld_dst    = 1'b1;
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_LEN;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_LEN: begin
                    nxt_d.acc = hdr_word[ACC_W-9:0];
                    if (cur_q.cnt == CNT_W'(LEN_BYTES - 1)) begin
                        ld_len    = 1'b1;
                        nxt_d.cnt = '0;
                        if (len_word > LEN_W'(MAX_PAY)) begin
                            nxt_d.err = 1'b1;
                            nxt_d.st  = ST_SRC;
                        end else if (len_word == '0) begin
                            nxt_d.done = 1'b1;
                            nxt_d.st   = ST_SRC;
                        end else begin
                            nxt_d.plast = CNT_W'(len_word - LEN_W'(1));
                            nxt_d.st    = ST_PAY;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_PAY: begin
                    wr_en = 1'b1;
                    if (cur_q.cnt == cur_q.plast) begin
                        nxt_d.done = 1'b1;
                        nxt_d.cnt  = '0;
                        nxt_d.st   = ST_SRC;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                default: nxt_d.st = ST_SRC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: ST_SRC, cnt: '0, acc: '0, plast: '0, done: 1'b0, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pkt_done = cur_q.done;
    assign pkt_err  = cur_q.err;
endmodule

// File: rtl/pkt_field_reg.sv
`timescale 1ns/1ps
module pkt_field_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (ld) val_d = d;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/pkt_payload_buf.sv
`timescale 1ns/1ps
module pkt_payload_buf #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pkt_hdr_parser.sv
`timescale 1ns/1ps
module pkt_hdr_parser #(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_BYTES  = 2,
    parameter int MAX_PAY    = 32,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int LEN_W     = 8 * LEN_BYTES,
    localparam int ACC_W     = (ADDR_W > LEN_W) ? ADDR_W : LEN_W,
    localparam int OFF_W     = $clog2(MAX_PAY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [LEN_W-1:0]  pay_len,
    output logic              pkt_done,
    output logic              pkt_err,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);
    logic [ACC_W-1:0] hdr_word;
    logic             ld_src, ld_dst, ld_len, wr_en;
    logic [OFF_W-1:0] wr_off;

    pkt_hdr_fsm #(
        .ADDR_BYTES(ADDR_BYTES), .LEN_BYTES(LEN_BYTES), .MAX_PAY(MAX_PAY)
    ) i_fsm (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_word(hdr_word), .ld_src(ld_src), .ld_dst(ld_dst), .ld_len(ld_len),
        .wr_en(wr_en), .wr_off(wr_off), .pkt_done(pkt_done), .pkt_err(pkt_err)
    );

    pkt_field_reg #(.W(ADDR_W)) i_src (
        .clk(clk), .rst(rst), .ld(ld_src), .d(hdr_word[ADDR_W-1:0]), .q(src_addr)
    );

    pkt_field_reg #(.W(ADDR_W)) i_dst (
        .clk(clk), .rst(rst), .ld(ld_dst), .d(hdr_word[ADDR_W-1:0]), .q(dst_addr)
    );

    pkt_field_reg #(.W(LEN_W)) i_len (
        .clk(clk), .rst(rst), .ld(ld_len), .d(hdr_word[LEN_W-1:0]), .q(pay_len)
    );

    pkt_payload_buf #(.DEPTH(MAX_PAY)) i_buf (
        .clk(clk), .we(wr_en), .waddr(wr_off), .wdata(in_byte),
        .raddr(rd_idx), .rdata(rd_byte)
    );
endmodule

// File: rtl/pkt_hdr_parser_chk.sv
`timescale 1ns/1ps
module pkt_hdr_parser_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [LEN_W-1:0]  pay_len,
    input logic              pkt_done,
    input logic              pkt_err
);
    // R5: the completion strobe never lasts two cycles
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);

    // R6: a rejected packet never also completes
    a_r6_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pkt_done && pkt_err));

    // R1: an idle cycle cannot produce a completion
    a_r1_no_done_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !pkt_done);

    // R1: field registers hold across idle cycles
    a_r1_fields_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(src_addr) && $stable(dst_addr) && $stable(pay_len)));

    // R9: the error flag only moves when a byte is consumed
    a_r9_err_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pkt_err));

    // R10: reset clears strobe, flag and fields
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!pkt_done && !pkt_err && src_addr == '0 && dst_addr == '0 && pay_len == '0));
endmodule

bind pkt_hdr_parser pkt_hdr_parser_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_addr(src_addr),
    .dst_addr(dst_addr), .pay_len(pay_len), .pkt_done(pkt_done), .pkt_err(pkt_err)
);

// File: tb/test_pkt_hdr_parser.sv
`timescale 1ns/1ps
module test_pkt_hdr_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] pay_len;
    logic        pkt_done, pkt_err;
    logic [4:0]  rd_idx = 5'd0;
    logic [7:0]  rd_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic        exp_done = 1'b0;
    logic        exp_err = 1'b0;
    logic [31:0] exp_src = '0;
    logic [31:0] exp_dst = '0;
    logic [15:0] exp_len = '0;
    logic [7:0]  exp_buf [32];

    always #2 clk = ~clk;

    pkt_hdr_parser i_pkt_hdr_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .src_addr(src_addr), .dst_addr(dst_addr), .pay_len(pay_len),
        .pkt_done(pkt_done), .pkt_err(pkt_err), .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Check the result of the previous edge, then drive the next cycle.
    task automatic tick(input logic v, input logic [7:0] b);
        @(negedge clk);
        chk("R5/R7", "pkt_done", 32'(pkt_done), 32'(exp_done));
        chk("R6/R9", "pkt_err", 32'(pkt_err), 32'(exp_err));
        chk("R2/R3", "src_addr", src_addr, exp_src);
        chk("R2/R3", "dst_addr", dst_addr, exp_dst);
        chk("R2/R3", "pay_len", 32'(pay_len), 32'(exp_len));
        exp_done = 1'b0;
        in_valid = v;
        in_byte  = b;
    endtask

    function automatic logic [7:0] pay_val(input int seed, input int k);
        return 8'(seed * 7 + k * 13 + 5);
    endfunction

    // R1/R8: gap inserts idle cycles; without gaps packets run back to back
    task automatic send_pkt(input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] len, input bit gap, input int seed);
        logic [7:0] hdr [10];
        int npay;
        hdr[0] = s[31:24]; hdr[1] = s[23:16]; hdr[2] = s[15:8]; hdr[3] = s[7:0];
        hdr[4] = d[31:24]; hdr[5] = d[23:16]; hdr[6] = d[15:8]; hdr[7] = d[7:0];
        hdr[8] = len[15:8]; hdr[9] = len[7:0];
        npay = (len <= 16'd32) ? int'(len) : 0;
        for (int i = 0; i < 10; i++) begin
            if (gap && (i % 3 == 1)) tick(1'b0, 8'hA5);
            tick(1'b1, hdr[i]);
            if (i == 0) exp_err = 1'b0;
            if (i == 3) exp_src = s;
            if (i == 7) exp_dst = d;
            if (i == 9) begin
                exp_len = len;
                if (len > 16'd32) exp_err = 1'b1;
                else if (len == 16'd0) exp_done = 1'b1;
            end
        end
        for (int k = 0; k < npay; k++) begin
            logic [7:0] b;
            if (gap && (k % 4 == 2)) tick(1'b0, 8'h3C);
            b = pay_val(seed, k);
            tick(1'b1, b);
            exp_buf[k] = b;
            if (k == npay - 1) exp_done = 1'b1;
        end
    endtask

    // R4: read back store entries through rd_idx during idle cycles
    task automatic check_buf(input int n);
        for (int j = 0; j < n; j++) begin
            tick(1'b0, 8'h00);
            rd_idx = 5'(j);
            #1;
            chk("R4", "rd_byte", 32'(rd_byte), 32'(exp_buf[j]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 32; j++) exp_buf[j] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: first tick checks the reset state
        tick(1'b0, 8'h00);

        // Length sweep 0..33 (R2, R3, R5, R6, R7, R8); odd lengths carry idle gaps (R1)
        for (int L = 0; L <= 33; L++) begin
            send_pkt({8'(L), 8'hC3, 8'(~L), 8'(L * 3)},
                     {8'(L + 1), 8'h5A, 8'(L * 5), 8'h11},
                     16'(L), bit'(L % 2), L);
            if (L % 3 == 0) check_buf((L > 32) ? 32 : L);
        end

        // R6: upper length byte counts; payload store untouched by rejected packet
        send_pkt(32'h01020304, 32'h05060708, 16'h0105, 1'b0, 40);
        // R8/R9: good packet directly after the rejected one
        send_pkt(32'hDEADBEEF, 32'hCAFEF00D, 16'd5, 1'b0, 41);
        check_buf(32);

        // R6 all-ones length, then R7 zero length back to back
        send_pkt(32'h11223344, 32'h55667788, 16'hFFFF, 1'b1, 42);
        send_pkt(32'h99AABBCC, 32'hDDEEFF00, 16'd0, 1'b0, 43);
        check_buf(32);

        // R10: reset in the middle of a header, byte offered during reset ignored
        send_pkt(32'h0BADF00D, 32'h12345678, 16'd3, 1'b0, 44);
        tick(1'b1, 8'h71);
        tick(1'b1, 8'h72);
        tick(1'b1, 8'h73);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_byte = 8'hEE;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        exp_src = '0; exp_dst = '0; exp_len = '0; exp_err = 1'b0; exp_done = 1'b0;
        tick(1'b0, 8'h00);
        // R8: parse restarts at byte 0 after reset
        send_pkt(32'hF0E1D2C3, 32'hB4A59687, 16'd32, 1'b1, 45);
        check_buf(32);
        tick(1'b0, 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule